// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

The block gathers twelve interrupt sources and presents one of them at a time to a CPU. Each source owns a pending flag and an enable bit, both held in byte-wide registers on a simple CPU register bus. A single-cycle pulse (or level) on a source input sets its pending flag. The flag then holds until the CPU accepts that interrupt or software overwrites it. A flag counts toward a request only when its enable bit is 1 and the global interrupt flag input is 1. Among the flags that qualify, a fixed hardware order picks the winner. The block drives a request line and a 4-bit vector index for that winner.

The CPU accepts the presented interrupt by pulsing the acknowledge input. The flag that was granted in that cycle is cleared, and every other flag is left alone. Software may read, set or clear any flag at any time, for example to retire a request without servicing it or to raise one artificially. Register reads are combinational from the address. Writes take effect at the next clock edge.

Source order (vector index 0 = highest priority): 0 ext0, 1 ext1, 2 ext2, 3 ext3, 4 tmr0, 5 tmr1, 6 tmr2, 7 tmr3, 8 adc, 9 wdog, 10 tick, 11 uart.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all flags and enables are 0, `irq_o` is 0, and all four registers read 0.
- R2: A 1 on `src_req[i]` in a cycle makes flag i read 1 after that clock edge. Flag register 0xF7 holds source i (0..7) at bit 7-i. Flag register 0xF5 holds source i (8..11) at bit 15-i.
- R3: A set flag stays set over idle cycles, including while its source is disabled, until it is acknowledged or written.
- R4: When `irq_ack` is 1 while `irq_o` is 1, the flag of the source on `irq_vec` is cleared at that edge and no other flag changes.
- R5: Software writes to 0xF7 and 0xF5 set and clear flags. Bits 3..0 of 0xF5 are ignored on write and read 0.
- R6: Enable registers 0xF6 (sources 0..7 at bit 7-i) and 0xF4 (sources 8..11 at bit 15-i) are read/write, with bits 3..0 of 0xF4 reading 0.
- R7: `irq_o` is 1 exactly when `gie` is 1 and at least one flag has its enable bit set. A masked flag stays pending.
- R8: `irq_vec` is the lowest index whose flag and enable are both 1 (index 0 highest priority, 11 lowest). It reads 0 when `irq_o` is 0.
- R9: A source set in the same cycle as a software write of 0 or an acknowledge-clear of the same flag wins, and the flag stays 1.
- R10: `irq_ack` while `irq_o` is 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 12 | Set events, one per source, indexed by vector index |
| gie | input | 1 | Global interrupt enable |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request to CPU |
| irq_vec | output | 4 | Vector index of the granted source |
| irq_ack | input | 1 | CPU acceptance of the presented interrupt |

## Verification
The properties assume that the inputs are stable and known at each rising edge. They also assume that the acknowledge-clear property is judged only in cycles with no bus write and no source event, since either of these may legitimately rewrite the flags. The stimulus changes every input on the falling edge and holds it for a whole cycle. It raises writes, set events and acknowledges together only in the directed collision tests. Those tests are meant to show the set-wins rule at the ports.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int N_SRC  = 12;
    localparam int VEC_W  = $clog2(N_SRC);
    localparam int BYTE_W = 8;
    localparam int HI_CNT = BYTE_W;
    localparam int LO_CNT = N_SRC - HI_CNT;

    typedef struct packed {
        logic [N_SRC-1:0] flag;
        logic [N_SRC-1:0] en;
    } irq_state_t;
endpackage

// File: rtl/irq_byte_lane.sv
// Maps a slice of the source vector onto a register byte, MSB first,
// and maps write data back onto that slice.
module irq_byte_lane
    import irq_pkg::*;
#(
    parameter int BASE  = 0,
    parameter int WIDTH = 8
) (
    input  logic [N_SRC-1:0]  flag_vec,
    input  logic [N_SRC-1:0]  en_vec,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] flag_byte,
    output logic [BYTE_W-1:0] en_byte,
    output logic [WIDTH-1:0]  wfield
);
    localparam int PAD = BYTE_W - WIDTH;

    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
        assign flag_byte[BYTE_W-1-j] = flag_vec[BASE+j];
        assign en_byte[BYTE_W-1-j]   = en_vec[BASE+j];
        assign wfield[j]             = wdata[BYTE_W-1-j];
    end

    if (PAD > 0) begin : g_pad
        assign flag_byte[PAD-1:0] = '0;
        assign en_byte[PAD-1:0]   = '0;
        logic unused_w;
        assign unused_w = ^wdata[PAD-1:0];
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder: lowest set index wins.
module irq_prio_enc #(
    parameter int N = 12,
    parameter int W = 4
) (
    input  logic [N-1:0] req,
    output logic         valid,
    output logic [W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                valid = 1'b1;
                idx   = W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] A_EN_LO = 8'hF4,
    parameter logic [ADDR_W-1:0] A_FL_LO = 8'hF5,
    parameter logic [ADDR_W-1:0] A_EN_HI = 8'hF6,
    parameter logic [ADDR_W-1:0] A_FL_HI = 8'hF7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              gie,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic [VEC_W-1:0]  irq_vec,
    input  logic              irq_ack
);
    irq_state_t st_q, st_d;

    logic [N_SRC-1:0]  flag_vec, en_vec, pend_w;
    logic [BYTE_W-1:0] fl_hi_b, en_hi_b, fl_lo_b, en_lo_b;
    logic [HI_CNT-1:0] hi_field;
    logic [LO_CNT-1:0] lo_field;
    logic              grant_v;
    logic [VEC_W-1:0]  grant_idx;

    assign flag_vec = st_q.flag;
    assign en_vec   = st_q.en;

    irq_byte_lane #(.BASE(0), .WIDTH(HI_CNT)) u_lane_hi (
        .flag_vec (flag_vec),
        .en_vec   (en_vec),
        .wdata    (bus_wdata),
        .flag_byte(fl_hi_b),
        .en_byte  (en_hi_b),
        .wfield   (hi_field)
    );

    irq_byte_lane #(.BASE(HI_CNT), .WIDTH(LO_CNT)) u_lane_lo (
        .flag_vec (flag_vec),
        .en_vec   (en_vec),
        .wdata    (bus_wdata),
        .flag_byte(fl_lo_b),
        .en_byte  (en_lo_b),
        .wfield   (lo_field)
    );

    assign pend_w = flag_vec & en_vec & {N_SRC{gie}};

    irq_prio_enc #(.N(N_SRC), .W(VEC_W)) u_enc (
        .req  (pend_w),
        .valid(grant_v),
        .idx  (grant_idx)
    );

    assign irq_o   = grant_v;
    assign irq_vec = grant_idx;

    always_comb begin
        bus_rdata = '0;
        if      (bus_addr == A_FL_HI) bus_rdata = fl_hi_b;
        else if (bus_addr == A_FL_LO) bus_rdata = fl_lo_b;
        else if (bus_addr == A_EN_HI) bus_rdata = en_hi_b;
        else if (bus_addr == A_EN_LO) bus_rdata = en_lo_b;
    end

    // Next state: software write, then acceptance clear, then set events.
    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if      (bus_addr == A_FL_HI) st_d.flag[HI_CNT-1:0]     = hi_field;
            else if (bus_addr == A_FL_LO) st_d.flag[N_SRC-1:HI_CNT] = lo_field;
            else if (bus_addr == A_EN_HI) st_d.en[HI_CNT-1:0]       = hi_field;
            else if (bus_addr == A_EN_LO) st_d.en[N_SRC-1:HI_CNT]   = lo_field;
        end
        if (irq_ack && grant_v) begin
            st_d.flag[grant_idx] = 1'b0;
        end
        st_d.flag = st_d.flag | src_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_req,
    input logic             gie,
    input logic             bus_wr,
    input logic             irq_ack,
    input logic             irq_o,
    input logic [VEC_W-1:0] irq_vec,
    input logic [N_SRC-1:0] flags,
    input logic [N_SRC-1:0] enables
);
    // R2: every set event lands in its flag
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req != '0) |=> ((flags & $past(src_req)) == $past(src_req)));

    // R3: with no write and no acknowledge, no flag falls
    a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !irq_ack) |=> ((flags & $past(flags)) == $past(flags)));

    // R4: acceptance clears exactly the granted flag
    a_r4_ack_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_o && !bus_wr && src_req == '0)
        |=> (flags == ($past(flags) & ~(N_SRC'(1) << $past(irq_vec)))));

    // R7: no request without the global enable
    a_r7_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_o);

    // R8: granted source is pending, enabled, and has no higher pending peer
    a_r8_vec_is_top: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags[irq_vec] && enables[irq_vec]
                   && ((flags & enables & ((N_SRC'(1) << irq_vec) - N_SRC'(1))) == '0)));

    // R10: acknowledge without a request leaves flags alone
    a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_o && !bus_wr && src_req == '0) |=> $stable(flags));
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_req (src_req),
    .gie     (gie),
    .bus_wr  (bus_wr),
    .irq_ack (irq_ack),
    .irq_o   (irq_o),
    .irq_vec (irq_vec),
    .flags   (flag_vec),
    .enables (en_vec)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 8;
    // {src[11:0], en_hi[7:0], en_lo[7:0], gie, exp_irq, exp_vec[3:0]}
    localparam logic [33:0] VECS [NV] = '{
        {12'h001, 8'hFF, 8'hF0, 1'b1, 1'b1, 4'd0},
        {12'h880, 8'hFF, 8'hF0, 1'b1, 1'b1, 4'd7},
        {12'hFFF, 8'hFF, 8'hF0, 1'b1, 1'b1, 4'd0},
        {12'h600, 8'h00, 8'hF0, 1'b1, 1'b1, 4'd9},
        {12'h021, 8'h7F, 8'hF0, 1'b1, 1'b1, 4'd5},
        {12'h008, 8'hFF, 8'hF0, 1'b0, 1'b0, 4'd0},
        {12'h800, 8'h00, 8'h10, 1'b1, 1'b1, 4'd11},
        {12'h010, 8'h00, 8'h00, 1'b1, 1'b0, 4'd0}
    };

    logic        clk = 0, rst_n = 0;
    logic [11:0] src_req = '0;
    logic        gie = 0, bus_wr = 0, irq_ack = 0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        irq_o;
    logic [3:0]  irq_vec;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .gie(gie),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_vec(irq_vec),
        .irq_ack(irq_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_src(input logic [11:0] s);
        @(negedge clk);
        src_req = s;
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        irq_ack = 1;
        @(negedge clk);
        irq_ack = 0;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq", irq_o, 0);
        rd(8'hF4, r); chk("R1 F4", r, 0);
        rd(8'hF5, r); chk("R1 F5", r, 0);
        rd(8'hF6, r); chk("R1 F6", r, 0);
        rd(8'hF7, r); chk("R1 F7", r, 0);
        rst_n = 1;

        // R7 R8: table walk
        for (int v = 0; v < NV; v++) begin
            wr(8'hF7, 8'h00); wr(8'hF5, 8'h00);
            wr(8'hF6, VECS[v][21:14]); wr(8'hF4, VECS[v][13:6]);
            gie = VECS[v][5];
            pulse_src(VECS[v][33:22]);
            chk("R7 irq", irq_o, VECS[v][4]);
            chk("R8 vec", irq_vec, VECS[v][3:0]);
        end
        wr(8'hF7, 8'h00); wr(8'hF5, 8'h00);
        wr(8'hF6, 8'h00); wr(8'hF4, 8'h00);
        gie = 1;

        // R2: set events map onto register bits
        pulse_src(12'h402);
        rd(8'hF7, r); chk("R2 F7", r, 8'h40);
        rd(8'hF5, r); chk("R2 F5", r, 8'h20);
        // R3: held while disabled
        repeat (5) @(negedge clk);
        rd(8'hF7, r); chk("R3 F7", r, 8'h40);
        rd(8'hF5, r); chk("R3 F5", r, 8'h20);
        chk("R7 masked", irq_o, 0);

        // R5: software write of flags
        wr(8'hF7, 8'hFF); wr(8'hF5, 8'hFF);
        rd(8'hF7, r); chk("R5 F7", r, 8'hFF);
        rd(8'hF5, r); chk("R5 F5", r, 8'hF0);
        wr(8'hF7, 8'h00);
        rd(8'hF7, r); chk("R5 clr", r, 8'h00);
        wr(8'hF5, 8'h00);

        // R6: enables
        wr(8'hF6, 8'hA5); rd(8'hF6, r); chk("R6 F6", r, 8'hA5);
        wr(8'hF4, 8'hFF); rd(8'hF4, r); chk("R6 F4", r, 8'hF0);

        // R4 R8: acknowledge walk through all twelve
        wr(8'hF6, 8'hFF);
        wr(8'hF7, 8'hFF); wr(8'hF5, 8'hF0);
        for (int k = 0; k < 12; k++) begin
            chk("R4 irq", irq_o, 1);
            chk("R8 order", irq_vec, k);
            pulse_ack();
        end
        chk("R4 done", irq_o, 0);
        rd(8'hF7, r); chk("R4 F7", r, 8'h00);
        rd(8'hF5, r); chk("R4 F5", r, 8'h00);
        // R4: only the granted flag cleared
        wr(8'hF7, 8'h30);
        pulse_ack();
        rd(8'hF7, r); chk("R4 one", r, 8'h10);
        wr(8'hF7, 8'h00);

        // R7: global enable gating
        wr(8'hF5, 8'h80);
        gie = 0; #1;
        chk("R7 gie0", irq_o, 0);
        gie = 1; #1;
        chk("R7 gie1", irq_o, 1);
        chk("R7 vec", irq_vec, 8);
        wr(8'hF5, 8'h00);

        // R10: idle acknowledge
        pulse_ack();
        rd(8'hF7, r); chk("R10 empty", r, 8'h00);
        wr(8'hF6, 8'h00); wr(8'hF7, 8'h01);
        pulse_ack();
        rd(8'hF7, r); chk("R10 masked", r, 8'h01);
        wr(8'hF7, 8'h00);

        // R9: set beats software clear
        @(negedge clk);
        bus_addr = 8'hF7; bus_wdata = 8'h00; bus_wr = 1; src_req = 12'h004;
        @(negedge clk);
        bus_wr = 0; src_req = '0;
        rd(8'hF7, r); chk("R9 wr", r, 8'h20);
        // R9: set beats acknowledge clear
        wr(8'hF7, 8'h80); wr(8'hF6, 8'h80);
        @(negedge clk);
        irq_ack = 1; src_req = 12'h001;
        @(negedge clk);
        irq_ack = 0; src_req = '0;
        rd(8'hF7, r); chk("R9 ack", r, 8'h80);
        chk("R9 irq", irq_o, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule